// File: doc/BRIEF.md
# External Interrupt Pin Bank

This block sits between a group of external interrupt pins and one input of an interrupt controller. Every pin is first brought into the clock domain by a two-stage synchronizer. It then passes through a glitch filter that can be switched on or off per pin. The filter has two kinds: a delay filter with a fixed three-sample stability window, or a counted sampling filter with a programmable length. A trigger detector follows the filter. It can be set to fire on a rising edge, a falling edge, both edges, a low level or a high level.

A detected event sets the pin's pending bit. Software clears a pending bit by writing 1 to it. Each pending bit is gated by its own mask bit, and all pending bits that are not masked are ORed into one interrupt line. The handler reads the pending register to find out which pin raised the shared line.

Registers are reached through a plain write port and a combinational read port:
- Address 0: mask, one bit per pin; 1 blocks the pin.
- Address 1: pending, one bit per pin; writing 1 clears the bit.
- Address 2+i: configuration of pin i.
  - Bits [2:0]: trigger mode. 0 rising, 1 falling, 2 both edges, 3 low level, 4 high level, 5 to 7 off.
  - Bit 3: filter enable.
  - Bit 4: filter kind. 0 delay, 1 counted.
  - Bits [4+WW:5]: filter width.

Top module: `ext_irq_bank`

## Requirements
- R1: After reset, the pending register reads 0, the mask reads all ones, every configuration word reads 0, and `irq_o` is 0.
- R2: In mode 0 (rising) with the filter off, a pin that goes high sets its pending bit on the 4th rising clock edge after the change and not before. A falling change sets nothing.
- R3: In mode 1 (falling), only a high-to-low change sets the pending bit, with the same 4-edge latency.
- R4: In mode 2 (both), a change in either direction sets the pending bit.
- R5: In mode 4 (high level) or mode 3 (low level), the pending bit is set again on every cycle while the active level is present. A write-1 clear therefore only sticks once the level has gone.
- R6: An edge-set pending bit stays set until a 1 is written to its bit at address 1. Writing 0 bits, or 1s to other bits, leaves it unchanged.
- R7: When a detected event and a write-1 clear of the same bit fall in the same cycle, the pending bit stays set.
- R8: `irq_o` is 1 exactly when some pending bit has its mask bit at 0. A masked pin still records its pending bit.
- R9: With the filter on and kind 1 (counted) at width W, a new input level is accepted only after W+1 consecutive equal synchronized samples. A pulse of W cycles is ignored, and a held change sets pending on the (4+W)th edge.
- R10: With the filter on and kind 0 (delay), a level must hold for 3 samples, whatever the width field holds. A 2-cycle pulse is ignored, and a held change sets pending on the 6th edge.
- R11: Modes 5, 6 and 7 never set a pending bit, whatever the pin does.
- R12: A configuration word reads back with the field layout given above. Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPIN | External interrupt pins, asynchronous |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data, combinational |
| irq_o | output | 1 | Shared interrupt line |

## Verification
From a pin change, two synchronizer flops and the registered filter output bring the new level to the detector, and the pending bit is written one edge later. The result is due on edge 4 without a filter, on edge 4+W with the counted filter, and on edge 6 with the delay filter. Register writes and clears take effect on the edge that samples the strobe. The bench drives every input on the falling edge and reads the outputs on a later falling edge. Each latency check reads once one edge before the due edge, where the bit must still be clear, and once right after it. The same-cycle clear case places the write strobe on the exact edge where the detector's event lands.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int unsigned CFG_WW   = 6;
  localparam int unsigned DLY_NEED = 2;

  localparam logic [2:0] TRIG_RISE = 3'd0;
  localparam logic [2:0] TRIG_FALL = 3'd1;
  localparam logic [2:0] TRIG_BOTH = 3'd2;
  localparam logic [2:0] TRIG_LOW  = 3'd3;
  localparam logic [2:0] TRIG_HIGH = 3'd4;

  localparam int unsigned ADR_MASK = 0;
  localparam int unsigned ADR_PEND = 1;
  localparam int unsigned ADR_CFG0 = 2;

  // Length of the current run of equal samples, minus one, saturating at cap.
  function automatic int unsigned run_step(logic same, int unsigned run, int unsigned cap);
    if (!same) return 0;
    if (run >= cap) return cap;
    return run + 1;
  endfunction

  // Trigger decision from the filtered level now and one cycle earlier.
  function automatic logic trig_hit(logic [2:0] mode, logic cur, logic prev);
    case (mode)
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_BOTH: return cur ^ prev;
      TRIG_LOW:  return ~cur;
      TRIG_HIGH: return cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_filter.sv
module eirq_filter
  import ext_irq_pkg::*;
#(
  parameter int WW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_i,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic [WW-1:0] wid_i,
  output logic          q_o
);
  localparam int unsigned RUN_CAP = (1 << WW) - 1;

  logic          last_q;
  logic [WW-1:0] run_q;
  logic [WW-1:0] run_d;
  logic [WW-1:0] need;
  logic          take;
  logic          out_q;

  always_comb begin
    run_d = WW'(run_step(d_i == last_q, int'(run_q), RUN_CAP));
    need  = sel_i ? wid_i : WW'(DLY_NEED);
    take  = !en_i || (run_d >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      run_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      last_q <= d_i;
      run_q  <= run_d;
      if (take) out_q <= d_i;
    end
  end

  assign q_o = out_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  output logic       hit_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign hit_o = trig_hit(mode_i, lvl_i, prev_q);
endmodule

// File: rtl/ext_irq_bank.sv
module ext_irq_bank
  import ext_irq_pkg::*;
#(
  parameter  int NPIN = 8,
  parameter  int WW   = CFG_WW,
  localparam int CW   = 5 + WW,
  localparam int DW   = (NPIN > CW) ? NPIN : CW,
  localparam int AW   = $clog2(NPIN + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            irq_o
);
  logic [NPIN-1:0]   mask_q;
  logic [NPIN-1:0]   pend_q;
  logic [NPIN-1:0]   hit_vec;
  logic [NPIN-1:0]   clr_vec;
  logic [NPIN-1:0]   sync_vec;
  logic [NPIN-1:0]   filt_vec;
  logic [2:0]        mode_q [NPIN];
  logic [NPIN-1:0]   fen_q;
  logic [NPIN-1:0]   fsel_q;
  logic [WW-1:0]     wid_q  [NPIN];

  assign clr_vec = (wr_en && wr_addr == AW'(ADR_PEND)) ? wr_data[NPIN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
      fen_q  <= '0;
      fsel_q <= '0;
      for (int i = 0; i < NPIN; i++) begin
        mode_q[i] <= '0;
        wid_q[i]  <= '0;
      end
    end else begin
      pend_q <= (pend_q & ~clr_vec) | hit_vec;
      if (wr_en && wr_addr == AW'(ADR_MASK)) mask_q <= wr_data[NPIN-1:0];
      for (int i = 0; i < NPIN; i++) begin
        if (wr_en && wr_addr == AW'(ADR_CFG0 + i)) begin
          mode_q[i] <= wr_data[2:0];
          fen_q[i]  <= wr_data[3];
          fsel_q[i] <= wr_data[4];
          wid_q[i]  <= wr_data[CW-1:5];
        end
      end
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    eirq_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i[g]), .q_o(sync_vec[g])
    );
    eirq_filter #(.WW(WW)) u_filt (
      .clk(clk), .rst_n(rst_n), .d_i(sync_vec[g]), .en_i(fen_q[g]),
      .sel_i(fsel_q[g]), .wid_i(wid_q[g]), .q_o(filt_vec[g])
    );
    eirq_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl_i(filt_vec[g]), .mode_i(mode_q[g]),
      .hit_o(hit_vec[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADR_MASK)) rd_data = DW'(mask_q);
    if (rd_addr == AW'(ADR_PEND)) rd_data = DW'(pend_q);
    for (int i = 0; i < NPIN; i++) begin
      if (rd_addr == AW'(ADR_CFG0 + i))
        rd_data = DW'({wid_q[i], fsel_q[i], fen_q[i], mode_q[i]});
    end
  end

  assign irq_o = |(pend_q & ~mask_q);
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic [NPIN-1:0] pend_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] hit_vec,
  input logic [NPIN-1:0] clr_vec
);
  // R8
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o);

  // R8
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_q & ~mask_q) != '0));

  // R6
  pend_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

  // R7
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_vec) & ~pend_q) == '0));

  // R11
  pend_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit_vec)) == '0));
endmodule

bind ext_irq_bank ext_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pend_q(pend_q),
  .mask_q(mask_q), .hit_vec(hit_vec), .clr_vec(clr_vec)
);

// File: tb/sim_ext_irq_bank.sv
`timescale 1ns/1ps
module sim_ext_irq_bank;
  localparam int NPIN = 8;
  localparam int DW   = 11;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pin_i = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [DW-1:0]   rd_data;
  logic            irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write lands.
  task automatic wr(int addr, logic [DW-1:0] data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int addr, output logic [DW-1:0] v);
    rd_addr = AW'(addr);
    #1 v = rd_data;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] cfgw(int mode, bit fen, bit fsel, int w);
    return DW'(mode) | (DW'(fen) << 3) | (DW'(fsel) << 4) | (DW'(w) << 5);
  endfunction

  function automatic logic pbit(logic [DW-1:0] v, int b);
    return v[b];
  endfunction

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(0, v); check("R1 mask", v, 11'h0FF);
    rd(1, v); check("R1 pend", v, 0);
    rd(2, v); check("R1 cfg0", v, 0);
    rd(9, v); check("R1 cfg7", v, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_rise();
    logic [DW-1:0] v;
    wr(2, cfgw(0, 0, 0, 0));
    wr(0, 11'h0FE);
    pin_i[0] = 1'b1;
    edges(3); rd(1, v); check("R2 early", pbit(v, 0), 0);
    edges(1); rd(1, v); check("R2 due", pbit(v, 0), 1);
    check("R2 irq", irq_o, 1);
    wr(1, 11'h001);
    rd(1, v); check("R2 cleared", pbit(v, 0), 0);
    pin_i[0] = 1'b0;
    edges(6); rd(1, v); check("R2 fall ignored", pbit(v, 0), 0);
    check("R2 irq low", irq_o, 0);
  endtask

  task automatic t_fall();
    logic [DW-1:0] v;
    wr(3, cfgw(1, 0, 0, 0));
    pin_i[1] = 1'b1;
    edges(8); rd(1, v); check("R3 rise ignored", pbit(v, 1), 0);
    pin_i[1] = 1'b0;
    edges(3); rd(1, v); check("R3 early", pbit(v, 1), 0);
    edges(1); rd(1, v); check("R3 due", pbit(v, 1), 1);
    wr(1, 11'h002);
  endtask

  task automatic t_both();
    logic [DW-1:0] v;
    wr(4, cfgw(2, 0, 0, 0));
    pin_i[2] = 1'b1;
    edges(4); rd(1, v); check("R4 rise", pbit(v, 2), 1);
    wr(1, 11'h004);
    rd(1, v); check("R4 clr", pbit(v, 2), 0);
    pin_i[2] = 1'b0;
    edges(4); rd(1, v); check("R4 fall", pbit(v, 2), 1);
    wr(1, 11'h004);
  endtask

  task automatic t_level();
    logic [DW-1:0] v;
    wr(5, cfgw(4, 0, 0, 0));
    pin_i[3] = 1'b1;
    edges(4); rd(1, v); check("R5 high set", pbit(v, 3), 1);
    wr(1, 11'h008);
    rd(1, v); check("R5 high reasserts", pbit(v, 3), 1);
    pin_i[3] = 1'b0;
    edges(4);
    wr(1, 11'h008);
    rd(1, v); check("R5 high clr sticks", pbit(v, 3), 0);
    wr(6, cfgw(3, 0, 0, 0));
    edges(2); rd(1, v); check("R5 low set", pbit(v, 4), 1);
    wr(1, 11'h010);
    rd(1, v); check("R5 low reasserts", pbit(v, 4), 1);
    pin_i[4] = 1'b1;
    edges(5);
    wr(1, 11'h010);
    edges(2); rd(1, v); check("R5 low clr sticks", pbit(v, 4), 0);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] v;
    wr(7, cfgw(0, 0, 0, 0));
    pin_i[5] = 1'b1;
    edges(4); rd(1, v); check("R6 set", pbit(v, 5), 1);
    wr(1, 11'h000);
    rd(1, v); check("R6 zero write", pbit(v, 5), 1);
    wr(1, 11'h7DF);
    rd(1, v); check("R6 other bits", pbit(v, 5), 1);
    wr(1, 11'h020);
    edges(4); rd(1, v); check("R6 cleared stays", pbit(v, 5), 0);
  endtask

  task automatic t_same();
    logic [DW-1:0] v;
    wr(8, cfgw(0, 0, 0, 0));
    pin_i[6] = 1'b1;
    edges(3);
    wr(1, 11'h040);
    rd(1, v); check("R7 event wins", pbit(v, 6), 1);
    wr(1, 11'h040);
    rd(1, v); check("R7 later clr", pbit(v, 6), 0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    wr(0, 11'h0FF);
    pin_i[0] = 1'b1;
    edges(4); rd(1, v); check("R8 masked pend", pbit(v, 0), 1);
    check("R8 masked irq", irq_o, 0);
    wr(0, 11'h0FE);
    check("R8 unmasked irq", irq_o, 1);
    wr(0, 11'h0FD);
    check("R8 other unmasked", irq_o, 0);
    wr(1, 11'h001);
    wr(0, 11'h0FE);
    check("R8 no pend", irq_o, 0);
    pin_i[0] = 1'b0;
    edges(4);
  endtask

  task automatic t_digital();
    logic [DW-1:0] v;
    wr(9, cfgw(0, 1, 1, 4));
    edges(2);
    pin_i[7] = 1'b1;
    edges(4);
    pin_i[7] = 1'b0;
    edges(10); rd(1, v); check("R9 pulse W rejected", pbit(v, 7), 0);
    pin_i[7] = 1'b1;
    edges(7); rd(1, v); check("R9 early", pbit(v, 7), 0);
    edges(1); rd(1, v); check("R9 due", pbit(v, 7), 1);
    wr(1, 11'h080);
  endtask

  task automatic t_delay();
    logic [DW-1:0] v;
    wr(3, cfgw(0, 1, 0, 50));
    edges(2);
    pin_i[1] = 1'b1;
    edges(2);
    pin_i[1] = 1'b0;
    edges(8); rd(1, v); check("R10 pulse rejected", pbit(v, 1), 0);
    pin_i[1] = 1'b1;
    edges(5); rd(1, v); check("R10 early", pbit(v, 1), 0);
    edges(1); rd(1, v); check("R10 due", pbit(v, 1), 1);
    wr(1, 11'h002);
  endtask

  task automatic t_off();
    logic [DW-1:0] v;
    wr(4, cfgw(5, 0, 0, 0));
    pin_i[2] = 1'b1; edges(5);
    pin_i[2] = 1'b0; edges(5);
    rd(1, v); check("R11 mode5", pbit(v, 2), 0);
    wr(4, cfgw(7, 0, 0, 0));
    pin_i[2] = 1'b1; edges(6);
    rd(1, v); check("R11 mode7 high", pbit(v, 2), 0);
    wr(4, cfgw(6, 0, 0, 0));
    pin_i[2] = 1'b0; edges(6);
    rd(1, v); check("R11 mode6 low", pbit(v, 2), 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] v;
    wr(9, cfgw(2, 1, 1, 37));
    rd(9, v); check("R12 cfg layout", v, 11'h4BA);
    wr(12, 11'h000);
    rd(0, v); check("R12 mask untouched", v, 11'h0FE);
    rd(12, v); check("R12 unmapped read", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_w1c();
    t_same();
    t_mask();
    t_digital();
    t_delay();
    t_off();
    t_regs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule